// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog counter that runs on the system clock and escalates in two steps. When the count reaches the selected interval, it sets a sticky interrupt flag. This gives software a warning. If software still has not restarted the counter a fixed grace period later, the block emits a single-cycle reset request. The chip's reset tree is expected to act on that request.

Software controls the block through one six-bit control register. The register holds:

- an interval select,
- an interrupt enable,
- a reset enable,
- the sticky flag,
- a restart command bit that clears itself.

The interval and the grace period are parameters. The defaults give intervals of 2^12, 2^15, 2^18 and 2^21 clocks and a grace period of 512 clocks.

A new interval select is latched into the counter only when the count starts again from zero. That happens on a restart, on a return to zero at the reset boundary, and on the block's own reset. A time-out already in progress therefore always completes with the interval it started with.

Top module: `wdt_two_stage`

## Requirements
- R1: After a synchronous reset, the control register reads 0x00, `irq_o` is low and `wdt_rst_o` is low.
- R2: The control register layout is:
  - bit 0: restart;
  - bit 1: interrupt flag;
  - bit 2: interrupt enable;
  - bit 3: reset enable;
  - bits 5:4: interval select.

  A write updates the two enables and the select, and a read returns the stored values in the same positions.
- R3: Writing 1 to bit 0 clears the counter in that cycle. Bit 0 always reads back 0.
- R4: Let T = 2^(BASE_LOG2 + STEP_LOG2·sel). When the count reaches T and the interrupt enable is 1, the flag is set one cycle later. This is T+1 cycles after the restart write. `irq_o` equals flag AND interrupt enable.
- R5: The flag stays set until a write with bit 1 = 0. A write with bit 1 = 1 leaves the flag unchanged.
- R6: When the count reaches T+GRACE, the counter returns to zero, so the period is T+GRACE+1 cycles. If the reset enable is 1, `wdt_rst_o` is high for exactly one cycle, T+GRACE+1 cycles after the restart.
- R7: A restart written in the cycle when the count equals T+GRACE wins: no reset pulse is issued, and a new period starts.
- R8: A change of interval select without a restart does not alter the running time-out. It takes effect at the next return to zero or restart. A restart write applies the select carried in the same write.
- R9: After reset is released, counting starts from zero with select 00, exactly as after a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 6 | Control register write data |
| reg_rdata | output | 6 | Control register read data |
| irq_o | output | 1 | Interrupt request (flag AND interrupt enable) |
| wdt_rst_o | output | 1 | Single-cycle watchdog reset request |

## Verification
An internal fault shows up at the ports within one period of T+GRACE+1 cycles:

- A counter that is off by one moves the flag edge or the reset pulse by a cycle. The bench compares both outputs on every cycle of two full periods, so it sees the shift.
- A wrongly latched interval changes the spacing between reset pulses on the very next period.
- A lost restart appears as a reset pulse that should not have occurred.
- A flag that is not sticky drops `irq_o` before software clears it, and shows as a changed register read-back.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CTRL_W     = 6;
    localparam int BIT_RESTART = 0;
    localparam int BIT_FLAG    = 1;
    localparam int BIT_IRQ_EN  = 2;
    localparam int BIT_RST_EN  = 3;
    localparam int BIT_SEL_LO  = 4;
    localparam int BIT_SEL_HI  = 5;
    localparam int NUM_ITV     = 4;

    typedef enum logic [1:0] {
        ITV_0 = 2'd0,
        ITV_1 = 2'd1,
        ITV_2 = 2'd2,
        ITV_3 = 2'd3
    } wdt_sel_e;

    typedef struct packed {
        wdt_sel_e sel;
        logic     rst_en;
        logic     irq_en;
    } wdt_cfg_t;

    typedef struct packed {
        logic restart;
        logic flag_clr;
    } wdt_cmd_t;

    typedef struct packed {
        logic irq_hit;
        logic rst_hit;
    } wdt_hit_t;

    function automatic wdt_cfg_t decode_cfg(input logic [CTRL_W-1:0] d);
        wdt_cfg_t c;
        c.sel    = wdt_sel_e'(d[BIT_SEL_HI:BIT_SEL_LO]);
        c.rst_en = d[BIT_RST_EN];
        c.irq_en = d[BIT_IRQ_EN];
        return c;
    endfunction

    function automatic wdt_cmd_t decode_cmd(input logic wr, input logic [CTRL_W-1:0] d);
        wdt_cmd_t k;
        k.restart  = wr & d[BIT_RESTART];
        k.flag_clr = wr & ~d[BIT_FLAG];
        return k;
    endfunction

    function automatic logic [CTRL_W-1:0] encode_view(input wdt_cfg_t c, input logic flag);
        logic [CTRL_W-1:0] v;
        v                         = '0;
        v[BIT_SEL_HI:BIT_SEL_LO]  = c.sel;
        v[BIT_RST_EN]             = c.rst_en;
        v[BIT_IRQ_EN]             = c.irq_en;
        v[BIT_FLAG]               = flag;
        v[BIT_RESTART]            = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    input  logic              flag_i,
    output wdt_cfg_t          cfg_o,
    output wdt_sel_e          sel_next_o,
    output wdt_cmd_t          cmd_o,
    output logic [CTRL_W-1:0] reg_rdata
);

    wdt_cfg_t cfg_q;
    wdt_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            cfg_d = decode_cfg(reg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{sel: ITV_0, rst_en: 1'b0, irq_en: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o      = cfg_q;
    assign sel_next_o = cfg_d.sel;
    assign cmd_o      = decode_cmd(reg_wr, reg_wdata);
    assign reg_rdata  = encode_view(cfg_q, flag_i);

    // R3
    restart_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_o.restart |=> (reg_rdata[BIT_RESTART] == 1'b0));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 12,
    parameter int STEP_LOG2 = 3,
    parameter int GRACE     = 512
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     restart_i,
    input  wdt_sel_e sel_next_i,
    output wdt_hit_t hit_o
);

    localparam int MAX_LOG2 = BASE_LOG2 + STEP_LOG2 * (NUM_ITV - 1);
    localparam int CNT_W    = MAX_LOG2 + 1;

    logic [CNT_W-1:0] itv_tab [NUM_ITV];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cur_itv;
    logic [CNT_W-1:0] rst_lim;
    wdt_sel_e         act_sel_q;

    for (genvar i = 0; i < NUM_ITV; i++) begin : g_itv
        localparam int SH = BASE_LOG2 + STEP_LOG2 * i;
        assign itv_tab[i] = {{(CNT_W-1){1'b0}}, 1'b1} << SH;
    end

    assign cur_itv       = itv_tab[act_sel_q];
    assign rst_lim       = cur_itv + CNT_W'(GRACE);
    assign hit_o.irq_hit = (cnt_q == cur_itv);
    assign hit_o.rst_hit = (cnt_q == rst_lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            act_sel_q <= ITV_0;
        end else if (restart_i || hit_o.rst_hit) begin
            cnt_q     <= '0;
            act_sel_q <= sel_next_i;
        end else begin
            cnt_q     <= cnt_q + 1'b1;
        end
    end

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= rst_lim);

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> $stable(act_sel_q));

endmodule

// File: rtl/wdt_events.sv
module wdt_events
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wdt_hit_t hit_i,
    input  wdt_cmd_t cmd_i,
    input  logic     irq_en_i,
    input  logic     rst_en_i,
    output logic     flag_o,
    output logic     irq_o,
    output logic     rst_pulse_o
);

    logic flag_q;
    logic pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            if (hit_i.irq_hit && irq_en_i && !cmd_i.restart) begin
                flag_q <= 1'b1;
            end else if (cmd_i.flag_clr) begin
                flag_q <= 1'b0;
            end
            pulse_q <= hit_i.rst_hit && rst_en_i && !cmd_i.restart;
        end
    end

    assign flag_o      = flag_q;
    assign irq_o       = flag_q & irq_en_i;
    assign rst_pulse_o = pulse_q;

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !cmd_i.flag_clr) |=> flag_q);

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 12,
    parameter int STEP_LOG2 = 3,
    parameter int GRACE     = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              wdt_rst_o
);

    wdt_cfg_t cfg;
    wdt_sel_e sel_next;
    wdt_cmd_t cmd;
    wdt_hit_t hit;
    logic     flag;

    wdt_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .flag_i     (flag),
        .cfg_o      (cfg),
        .sel_next_o (sel_next),
        .cmd_o      (cmd),
        .reg_rdata  (reg_rdata)
    );

    wdt_counter #(
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2),
        .GRACE     (GRACE)
    ) u_counter (
        .clk        (clk),
        .rst        (rst),
        .restart_i  (cmd.restart),
        .sel_next_i (sel_next),
        .hit_o      (hit)
    );

    wdt_events u_events (
        .clk         (clk),
        .rst         (rst),
        .hit_i       (hit),
        .cmd_i       (cmd),
        .irq_en_i    (cfg.irq_en),
        .rst_en_i    (cfg.rst_en),
        .flag_o      (flag),
        .irq_o       (irq_o),
        .rst_pulse_o (wdt_rst_o)
    );

    // R7
    restart_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.restart |=> !wdt_rst_o);

    // R6
    reset_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_o |-> $past(cfg.rst_en));

    // R4
    flag_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(cfg.irq_en));

endmodule

// File: tb/tb_wdt_two_stage.sv
module tb_wdt_two_stage;

    localparam int BASE = 4;
    localparam int STEP = 1;
    localparam int GR   = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [5:0] reg_wdata = '0;
    logic [5:0] reg_rdata;
    logic       irq_o;
    logic       wdt_rst_o;

    int checks = 0;
    int fails  = 0;
    int T, P, P3;
    logic ie, re, flag_exp;

    always #4 clk = ~clk;

    wdt_two_stage #(.BASE_LOG2(BASE), .STEP_LOG2(STEP), .GRACE(GR)) dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o),
        .wdt_rst_o (wdt_rst_o)
    );

    function automatic logic [5:0] enc(input int sel, input logic r_en, input logic i_en,
                                       input logic fl, input logic rs);
        logic [1:0] s2;
        s2 = 2'(sel);
        return {s2, r_en, i_en, fl, rs};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // called at a negedge; write is sampled at the next posedge; returns at the following negedge
    task automatic do_write(input logic [5:0] d);
        reg_wr    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 rdata", reg_rdata, 6'h00);
        chk("R1 irq", irq_o, 1'b0);
        chk("R1 rst", wdt_rst_o, 1'b0);

        // R9 counting starts at release with select 00: enable reset without restart
        rst = 1'b0;
        do_write(enc(0, 1'b1, 1'b0, 1'b0, 1'b0));
        P = (1 << BASE) + GR + 1;
        for (int m = 2; m <= P + 1; m++) begin
            @(negedge clk);
            chk("R9 first period from release", wdt_rst_o, (m == P));
        end

        // R2 R3 R4 R6 R8 sweep over select and enables, restart write carries new select
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 4; e++) begin
                ie = e[0];
                re = e[1];
                T  = 1 << (BASE + STEP * s);
                P  = T + GR + 1;
                flag_exp = 1'b0;
                do_write(enc(s, re, ie, 1'b0, 1'b1));
                chk("R2 readback", reg_rdata, enc(s, re, ie, 1'b0, 1'b0));
                chk("R3 restart bit reads 0", reg_rdata[0], 1'b0);
                for (int m = 1; m <= 2 * P; m++) begin
                    @(negedge clk);
                    if ((m % P) == T + 1 && ie) flag_exp = 1'b1;
                    chk("R4 irq timing", irq_o, flag_exp & ie);
                    chk("R5 flag readback", reg_rdata[1], flag_exp);
                    chk("R6 reset pulse", wdt_rst_o, re && (m % P) == 0);
                end
            end
        end

        // R5 flag write 1 keeps, write 0 clears
        do_write(enc(3, 1'b1, 1'b1, 1'b1, 1'b0));
        chk("R5 write 1 keeps flag", irq_o, 1'b1);
        do_write(enc(3, 1'b1, 1'b1, 1'b0, 1'b0));
        chk("R5 write 0 clears irq", irq_o, 1'b0);
        chk("R5 write 0 clears flag", reg_rdata[1], 1'b0);

        // R7 restart at the reset boundary wins
        T = 1 << BASE;
        P = T + GR + 1;
        do_write(enc(0, 1'b1, 1'b0, 1'b0, 1'b1));
        for (int m = 1; m <= T + GR; m++) begin
            @(negedge clk);
            chk("R7 no early reset", wdt_rst_o, 1'b0);
        end
        do_write(enc(0, 1'b1, 1'b0, 1'b0, 1'b1));
        chk("R7 boundary restart suppresses reset", wdt_rst_o, 1'b0);
        for (int m = 1; m <= P; m++) begin
            @(negedge clk);
            chk("R7 new period after restart", wdt_rst_o, (m == P));
        end

        // R8 select change without restart waits for return to zero
        P3 = (1 << (BASE + 3 * STEP)) + GR + 1;
        do_write(enc(0, 1'b1, 1'b0, 1'b0, 1'b1));
        for (int m = 1; m <= 4; m++) begin
            @(negedge clk);
            chk("R8 pre-change", wdt_rst_o, 1'b0);
        end
        do_write(enc(3, 1'b1, 1'b0, 1'b0, 1'b0));
        chk("R8 select readback", reg_rdata, enc(3, 1'b1, 1'b0, 1'b0, 1'b0));
        for (int m = 6; m <= P + P3 + 2; m++) begin
            @(negedge clk);
            chk("R8 running time-out kept, new select next", wdt_rst_o,
                (m == P) || (m == P + P3));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule